// File: doc/BRIEF.md
# MCMC Order Proposal and Acceptance Unit

This block holds the current topological ordering used by a Bayesian-network order sampler and walks it through a Markov chain. The ordering is stored as a square one-hot matrix: row `i` carries a 1 in column `j` when node `j` comes before node `i`, so row `i` lists the nodes allowed to be parents of node `i`. Each step picks two distinct nodes, exchanges their places in the ordering, and sends the resulting matrix to an external scorer. The scorer answers with the total log-domain score.

All scores are signed 32-bit fixed point in base-2 log units with 8 fraction bits. The block accepts or rejects each proposal with a Metropolis-Hastings test. It subtracts the held score from the new score and compares the difference with the base-2 log of a uniform random number. That log is drawn from an on-chip LFSR and a computed lookup table. Configuration is applied by a start pulse: node count, iteration count, seed and initial order. The block first has the initial order scored, then performs the programmed number of decisions and holds `done`. A node count below 2 is treated as 2, and one above the synthesized maximum is treated as the maximum.

Top module: `orderSampler`

## Requirements
- R1: While reset is held and after it is released, `propValid`, `stepValid` and `done` are low and `curOrder` and `curScore` are zero.
- R2: A `start` pulse when idle or done loads the node count, iteration count, seed and initial order. A zero seed is replaced by 1. The first proposal is the initial order unchanged. The score returned for it becomes `curScore`, and no decision is reported for it.
- R3: The random source is a 16-bit shift-left LFSR, `next = {L[14:0], L[15]^L[13]^L[12]^L[10]}`. Each draw attempt takes `a = L[7:0] mod n` and `b = L[15:8] mod n` from the current value and then steps the LFSR once. When `a == b` the draw is repeated on the next cycle.
- R4: A proposal is the held matrix with rows `a` and `b` exchanged and columns `a` and `b` exchanged. Bit `i*MAX_NODES + j` of a matrix port is row `i`, column `j`.
- R5: `propValid` stays high with a steady `propOrder` until `scoreValid` is seen. A `scoreValid` pulse while `propValid` is low changes neither `curOrder` nor `curScore`.
- R6: At a decision the threshold is formed from `u = L[5:0]` of the current LFSR value, which is then stepped once. With `v = u + 1` and `p = floor(log2 v)`, the threshold is `256*p + floor(256*(v - 2^p) / 2^p) - 1536`, which always lies in -1536..0.
- R7: A proposal is accepted exactly when `scoreIn - curScore >= threshold`. The difference is computed without overflow, so a difference of zero or more is always accepted.
- R8: On acceptance `curOrder` and `curScore` take the proposal and its score. On rejection both are kept. One cycle after the score is taken, `stepValid` pulses with `stepAccept` giving the outcome.
- R9: Exactly the programmed number of decisions is made. `done` then rises and stays high, with no further proposals, until the next `start`. With a count of zero, `done` rises right after the initial order is scored.
- R10: Any node count from 2 up to `MAX_NODES` works at run time. Rows and columns at or above the node count are never moved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load configuration and begin a run |
| cfgNodes | input | $clog2(MAX_NODES+1) | Active node count |
| cfgIters | input | ITER_W | Number of accept/reject decisions |
| cfgSeed | input | 16 | LFSR seed |
| cfgOrder | input | MAX_NODES*MAX_NODES | Initial order matrix |
| propValid | output | 1 | A proposal is waiting for its score |
| propOrder | output | MAX_NODES*MAX_NODES | Proposed order matrix |
| scoreValid | input | 1 | Scorer result valid |
| scoreIn | input | SCORE_W | Log-domain score of `propOrder` |
| curOrder | output | MAX_NODES*MAX_NODES | Currently held order |
| curScore | output | SCORE_W | Score of the held order |
| stepValid | output | 1 | One-cycle pulse per decision |
| stepAccept | output | 1 | Outcome of the last decision |
| done | output | 1 | Run finished |

## Verification
With two nodes, half of the draws give equal indices. A design without redraw would hand the scorer an unchanged matrix, and the proposal compare catches that. A scorer that always returns the same value makes every difference zero, so a design that uses a strict compare or gets the threshold sign wrong rejects steps it must accept. A zero seed would freeze an LFSR that does not replace it, and a zero iteration count would make a counter that decrements before testing run for 65535 steps. A stray `scoreValid` while no proposal is waiting would overwrite the held score in a design that does not gate it.

// File: rtl/orderSamplerPkg.sv
package orderSamplerPkg;

  localparam int LFSR_W = 16;
  localparam int DRAW_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_DRAW,
    ST_PROP,
    ST_DONE
  } stateT;

  typedef struct packed {
    logic loadCfg;
    logic initScore;
    logic drawTry;
    logic decide;
  } ctrlT;

  function automatic logic [LFSR_W-1:0] lfsrNext(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/orderSamplerCtrl.sv
module orderSamplerCtrl
  import orderSamplerPkg::*;
#(
  parameter int ITER_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ITER_W-1:0] cfgIters,
  input  logic              scoreValid,
  input  logic              drawOk,
  output ctrlT              ctrl,
  output logic              propValid,
  output logic              stepValid,
  output logic              done
);

  stateT             state, stateNext;
  logic [ITER_W-1:0] itersLeft;

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          ctrl.loadCfg = 1'b1;
          stateNext    = ST_INIT;
        end
      end
      ST_INIT: begin
        if (scoreValid) begin
          ctrl.initScore = 1'b1;
          stateNext      = (itersLeft == '0) ? ST_DONE : ST_DRAW;
        end
      end
      ST_DRAW: begin
        ctrl.drawTry = 1'b1;
        if (drawOk) stateNext = ST_PROP;
      end
      ST_PROP: begin
        if (scoreValid) begin
          ctrl.decide = 1'b1;
          stateNext   = (itersLeft == ITER_W'(1)) ? ST_DONE : ST_DRAW;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      itersLeft <= '0;
      stepValid <= 1'b0;
    end else begin
      state     <= stateNext;
      stepValid <= ctrl.decide;
      if (ctrl.loadCfg)     itersLeft <= cfgIters;
      else if (ctrl.decide) itersLeft <= itersLeft - ITER_W'(1);
    end
  end

  assign propValid = (state == ST_INIT) || (state == ST_PROP);
  assign done      = (state == ST_DONE);

  // R5
  prop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    propValid && !scoreValid |=> propValid);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !propValid);

  // R8
  step_after_score_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepValid |-> $past(propValid) && $past(scoreValid));

endmodule

// File: rtl/orderSamplerDatapath.sv
module orderSamplerDatapath
  import orderSamplerPkg::*;
#(
  parameter  int MAX_NODES = 8,
  parameter  int SCORE_W   = 32,
  parameter  int FRAC_W    = 8,
  parameter  int UNIF_W    = 6,
  localparam int NODE_W    = $clog2(MAX_NODES + 1),
  localparam int MAT_W     = MAX_NODES * MAX_NODES
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlT                      ctrl,
  input  logic [NODE_W-1:0]         cfgNodes,
  input  logic [LFSR_W-1:0]         cfgSeed,
  input  logic [MAT_W-1:0]          cfgOrder,
  input  logic signed [SCORE_W-1:0] scoreIn,
  output logic                      drawOk,
  output logic [MAT_W-1:0]          propOrder,
  output logic [MAT_W-1:0]          curOrder,
  output logic signed [SCORE_W-1:0] curScore,
  output logic                      stepAccept
);

  localparam int MAT_IW = $clog2(MAT_W);
  localparam int TAB_N  = 1 << UNIF_W;

  logic [LFSR_W-1:0]         lfsr;
  logic [NODE_W-1:0]         nodesR, nodesEff;
  logic [DRAW_W-1:0]         nodesW, idxA, idxB;
  logic [MAT_W-1:0]          curOrderR, propOrderR, swapped;
  logic signed [SCORE_W-1:0] curScoreR;
  logic                      stepAcceptR;
  logic signed [SCORE_W-1:0] logTab [TAB_N];
  logic signed [SCORE_W-1:0] threshold;
  logic signed [SCORE_W:0]   diffX, thrX;
  logic                      acceptNow;

  // clamp runtime node count into 2..MAX_NODES
  always_comb begin
    if (cfgNodes < NODE_W'(2))              nodesEff = NODE_W'(2);
    else if (cfgNodes > NODE_W'(MAX_NODES)) nodesEff = NODE_W'(MAX_NODES);
    else                                    nodesEff = cfgNodes;
  end

  // swap index draw
  assign nodesW = DRAW_W'(nodesR);
  assign idxA   = lfsr[DRAW_W-1:0] % nodesW;
  assign idxB   = lfsr[LFSR_W-1:DRAW_W] % nodesW;
  assign drawOk = (idxA != idxB);

  function automatic int mapIdx(input int k, input logic [DRAW_W-1:0] a,
                                input logic [DRAW_W-1:0] b);
    if (k == int'(a)) return int'(b);
    if (k == int'(b)) return int'(a);
    return k;
  endfunction

  // row and column exchange network
  always_comb begin
    swapped = '0;
    for (int r = 0; r < MAX_NODES; r++) begin
      for (int c = 0; c < MAX_NODES; c++) begin
        swapped[MAT_IW'(r * MAX_NODES + c)] =
          curOrderR[MAT_IW'(mapIdx(r, idxA, idxB) * MAX_NODES + mapIdx(c, idxA, idxB))];
      end
    end
  end

  // base-2 log of (u+1)/2^UNIF_W, piecewise linear, FRAC_W fraction bits
  function automatic int log2Fix(input int v);
    int p;
    p = 0;
    for (int e = 1; e <= UNIF_W; e++) begin
      if (v >= (1 << e)) p = e;
    end
    return (p << FRAC_W) + (((v - (1 << p)) << FRAC_W) >>> p) - (UNIF_W << FRAC_W);
  endfunction

  for (genvar k = 0; k < TAB_N; k++) begin : g_logTab
    assign logTab[k] = SCORE_W'(log2Fix(k + 1));
  end

  assign threshold = logTab[lfsr[UNIF_W-1:0]];
  assign diffX     = (SCORE_W+1)'(scoreIn) - (SCORE_W+1)'(curScoreR);
  assign thrX      = (SCORE_W+1)'(threshold);
  assign acceptNow = (diffX >= thrX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr        <= LFSR_W'(1);
      nodesR      <= NODE_W'(2);
      curOrderR   <= '0;
      propOrderR  <= '0;
      curScoreR   <= '0;
      stepAcceptR <= 1'b0;
    end else begin
      if (ctrl.loadCfg) begin
        nodesR      <= nodesEff;
        lfsr        <= (cfgSeed == '0) ? LFSR_W'(1) : cfgSeed;
        curOrderR   <= cfgOrder;
        propOrderR  <= cfgOrder;
        stepAcceptR <= 1'b0;
      end
      if (ctrl.initScore) curScoreR <= scoreIn;
      if (ctrl.drawTry) begin
        lfsr <= lfsrNext(lfsr);
        if (drawOk) propOrderR <= swapped;
      end
      if (ctrl.decide) begin
        lfsr        <= lfsrNext(lfsr);
        stepAcceptR <= acceptNow;
        if (acceptNow) begin
          curOrderR <= propOrderR;
          curScoreR <= scoreIn;
        end
      end
    end
  end

  assign propOrder  = propOrderR;
  assign curOrder   = curOrderR;
  assign curScore   = curScoreR;
  assign stepAccept = stepAcceptR;

  // R4
  swap_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.drawTry && drawOk |=> $countones(propOrderR) == $countones(curOrderR));

  // R6
  thr_nonpos_chk: assert property (@(posedge clk) disable iff (!rstN)
    threshold <= 0);

  // R7
  nonneg_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.decide && (scoreIn >= curScoreR) |=> stepAcceptR);

  // R8
  reject_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.decide) && !stepAcceptR |-> $stable(curOrderR) && $stable(curScoreR));

  // R8
  accept_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.decide) && stepAcceptR |->
      (curOrderR == $past(propOrderR)) && (curScoreR == $past(scoreIn)));

endmodule

// File: rtl/orderSampler.sv
module orderSampler
  import orderSamplerPkg::*;
#(
  parameter  int MAX_NODES = 8,
  parameter  int SCORE_W   = 32,
  parameter  int FRAC_W    = 8,
  parameter  int UNIF_W    = 6,
  parameter  int ITER_W    = 16,
  localparam int NODE_W    = $clog2(MAX_NODES + 1),
  localparam int MAT_W     = MAX_NODES * MAX_NODES
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [NODE_W-1:0]         cfgNodes,
  input  logic [ITER_W-1:0]         cfgIters,
  input  logic [LFSR_W-1:0]         cfgSeed,
  input  logic [MAT_W-1:0]          cfgOrder,
  output logic                      propValid,
  output logic [MAT_W-1:0]          propOrder,
  input  logic                      scoreValid,
  input  logic signed [SCORE_W-1:0] scoreIn,
  output logic [MAT_W-1:0]          curOrder,
  output logic signed [SCORE_W-1:0] curScore,
  output logic                      stepValid,
  output logic                      stepAccept,
  output logic                      done
);

  ctrlT ctrl;
  logic drawOk;

  orderSamplerCtrl #(.ITER_W(ITER_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .cfgIters   (cfgIters),
    .scoreValid (scoreValid),
    .drawOk     (drawOk),
    .ctrl       (ctrl),
    .propValid  (propValid),
    .stepValid  (stepValid),
    .done       (done)
  );

  orderSamplerDatapath #(
    .MAX_NODES (MAX_NODES),
    .SCORE_W   (SCORE_W),
    .FRAC_W    (FRAC_W),
    .UNIF_W    (UNIF_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .cfgNodes   (cfgNodes),
    .cfgSeed    (cfgSeed),
    .cfgOrder   (cfgOrder),
    .scoreIn    (scoreIn),
    .drawOk     (drawOk),
    .propOrder  (propOrder),
    .curOrder   (curOrder),
    .curScore   (curScore),
    .stepAccept (stepAccept)
  );

endmodule

// File: tb/orderSampler_test.sv
module orderSampler_test;

  localparam int MAXN = 8;
  localparam int SW   = 32;
  localparam int UW   = 6;
  localparam int IW   = 16;
  localparam int NW   = $clog2(MAXN + 1);
  localparam int MW   = MAXN * MAXN;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NW-1:0] cfgNodes = '0;
  logic [IW-1:0] cfgIters = '0;
  logic [15:0]   cfgSeed = '0;
  logic [MW-1:0] cfgOrder = '0;
  logic          propValid;
  logic [MW-1:0] propOrder;
  logic          scoreValid = 1'b0;
  logic signed [SW-1:0] scoreIn = '0;
  logic [MW-1:0] curOrder;
  logic signed [SW-1:0] curScore;
  logic stepValid, stepAccept, done;

  always #4 clk = ~clk;

  orderSampler #(.MAX_NODES(MAXN), .SCORE_W(SW), .FRAC_W(8), .UNIF_W(UW), .ITER_W(IW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .cfgNodes(cfgNodes), .cfgIters(cfgIters),
    .cfgSeed(cfgSeed), .cfgOrder(cfgOrder), .propValid(propValid), .propOrder(propOrder),
    .scoreValid(scoreValid), .scoreIn(scoreIn), .curOrder(curOrder), .curScore(curScore),
    .stepValid(stepValid), .stepAccept(stepAccept), .done(done)
  );

  typedef struct {
    logic [MW-1:0]        order;
    logic signed [SW-1:0] score;
    logic                 acc;
  } stepT;

  logic [MW-1:0] propQ[$];
  stepT          stepQ[$];
  int  nChecks = 0, nFails = 0;
  bit  constMode = 0;
  int  strayReq = 0, strayDone = 0;
  int  startCnt = 0, initSeen = 0;
  int  propSeen = 0;
  bit  svDrive = 0, pending = 0;
  int  delay = 0;
  logic [MW-1:0] expProp;
  stepT          expStep;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  function automatic logic [15:0] lfsrStepM(input logic [15:0] l);
    logic fb;
    fb = l[15] ^ l[13] ^ l[12] ^ l[10];
    return {l[14:0], fb};
  endfunction

  function automatic int thrM(input int u);
    int v, p, frac;
    v = u + 1;
    p = 0;
    while ((2 << p) <= v) p++;
    frac = ((v - (1 << p)) * 256) / (1 << p);
    return 256 * p + frac - 1536;
  endfunction

  function automatic logic signed [SW-1:0] scoreOf(input logic [MW-1:0] m);
    int s;
    if (constMode) return 32'sd500;
    s = 0;
    for (int i = 0; i < MAXN; i++)
      for (int j = 0; j < MAXN; j++)
        if (m[i*MAXN+j]) s += (((i * 7 + j * 13) % 23) - 11) * 37;
    return SW'(s);
  endfunction

  function automatic logic [MW-1:0] swapM(input logic [MW-1:0] m, input int a, input int b);
    logic [MW-1:0] r;
    int si, sj;
    for (int i = 0; i < MAXN; i++)
      for (int j = 0; j < MAXN; j++) begin
        si = (i == a) ? b : (i == b) ? a : i;
        sj = (j == a) ? b : (j == b) ? a : j;
        r[i*MAXN+j] = m[si*MAXN+sj];
      end
    return r;
  endfunction

  function automatic logic [MW-1:0] orderFromRot(input int n, input int rot);
    int pos[MAXN];
    logic [MW-1:0] m;
    m = '0;
    for (int p = 0; p < n; p++) pos[(n - 1 - p + rot) % n] = p;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n; j++)
        if (pos[j] < pos[i]) m[i*MAXN+j] = 1'b1;
    return m;
  endfunction

  // scorer model and scoreboard monitor
  always @(negedge clk) begin
    if (svDrive) begin
      scoreValid = 1'b0;
      svDrive    = 0;
      pending    = 0;
    end else if (pending) begin
      if (delay == 0) begin
        scoreIn    = scoreOf(propOrder);
        scoreValid = 1'b1;
        svDrive    = 1;
      end else delay--;
    end else if (propValid) begin
      pending = 1;
      delay   = propSeen % 3;
      propSeen++;
      if (propQ.size() == 0) begin
        check(0, "R3", "unexpected proposal", propOrder, '0);
      end else begin
        expProp = propQ.pop_front();
        if (startCnt != initSeen) begin
          initSeen++;
          check(propOrder == expProp, "R2", "initial proposal", propOrder, expProp);
        end else begin
          check(propOrder == expProp, "R3 R4", "swapped proposal", propOrder, expProp);
        end
      end
    end else if (strayReq != strayDone) begin
      scoreIn    = 32'sh0000_4321;
      scoreValid = 1'b1;
      svDrive    = 1;
      strayDone++;
    end
    if (stepValid === 1'b1) begin
      if (stepQ.size() == 0) begin
        check(0, "R8", "unexpected decision", 64'(stepAccept), 64'd0);
      end else begin
        expStep = stepQ.pop_front();
        check(stepAccept == expStep.acc, "R6 R7", "accept outcome",
              64'(stepAccept), 64'(expStep.acc));
        check(curOrder == expStep.order, "R8", "held order", curOrder, expStep.order);
        check(curScore == expStep.score, "R8", "held score",
              64'(curScore), 64'(expStep.score));
      end
    end
  end

  task automatic runSeq(input int n, input int iters, input logic [15:0] seed,
                        input int rot, input bit cmode, input string tag);
    logic [MW-1:0] m, cur, prop, outside;
    logic signed [SW-1:0] cs, s;
    logic [15:0] l;
    int a, b, thr, waitCyc;
    bit acc;
    constMode = cmode;
    m = orderFromRot(n, rot);
    propQ.push_back(m);
    l   = (seed == 16'h0) ? 16'h0001 : seed;
    cur = m;
    cs  = scoreOf(m);
    for (int it = 0; it < iters; it++) begin
      do begin
        a = int'(l[7:0]) % n;
        b = int'(l[15:8]) % n;
        l = lfsrStepM(l);
      end while (a == b);
      prop = swapM(cur, a, b);
      propQ.push_back(prop);
      s   = scoreOf(prop);
      thr = thrM(int'(l[UW-1:0]));
      l   = lfsrStepM(l);
      acc = (longint'(s) - longint'(cs) >= longint'(thr));
      if (acc) begin
        cur = prop;
        cs  = s;
      end
      stepQ.push_back('{cur, cs, acc});
    end
    @(negedge clk);
    cfgNodes = NW'(n);
    cfgIters = IW'(iters);
    cfgSeed  = seed;
    cfgOrder = m;
    startCnt++;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitCyc = 0;
    while (done !== 1'b1 && waitCyc < 30000) begin
      @(negedge clk);
      waitCyc++;
    end
    @(negedge clk);
    @(negedge clk);
    check(done === 1'b1, "R9", {tag, " done held"}, 64'(done), 64'd1);
    check(propQ.size() == 0 && stepQ.size() == 0, "R9", {tag, " decision count"},
          64'(propQ.size() + stepQ.size()), 64'd0);
    check(propValid === 1'b0, "R9", {tag, " no proposal after done"}, 64'(propValid), 64'd0);
    check(curOrder == cur, "R8", {tag, " final order"}, curOrder, cur);
    check(curScore == cs, "R8", {tag, " final score"}, 64'(curScore), 64'(cs));
    outside = '0;
    for (int i = 0; i < MAXN; i++)
      for (int j = 0; j < MAXN; j++)
        if (i >= n || j >= n) outside[i*MAXN+j] = curOrder[i*MAXN+j];
    check(outside == '0, "R10", {tag, " bits beyond node count"}, outside, '0);
    propQ.delete();
    stepQ.delete();
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d cycles, expected completion earlier", 150000);
    summary();
    $finish;
  end

  initial begin
    logic signed [SW-1:0] keepScore;
    logic [MW-1:0] keepOrder;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset values
    check(propValid === 1'b0, "R1", "propValid in reset", 64'(propValid), 64'd0);
    check(done === 1'b0, "R1", "done in reset", 64'(done), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(stepValid === 1'b0, "R1", "stepValid after reset", 64'(stepValid), 64'd0);
    check(curOrder === '0, "R1", "curOrder after reset", curOrder, '0);
    check(curScore === '0, "R1", "curScore after reset", 64'(curScore), 64'd0);
    // R5 stray score while idle
    strayReq++;
    repeat (3) @(negedge clk);
    check(curScore === '0, "R5", "stray score while idle", 64'(curScore), 64'd0);
    check(propValid === 1'b0, "R5", "no proposal while idle", 64'(propValid), 64'd0);

    runSeq(4, 24, 16'hACE1, 1, 1'b0, "n4");
    runSeq(8, 40, 16'h1D2B, 3, 1'b0, "n8");
    runSeq(2, 12, 16'h0000, 0, 1'b0, "n2 zero seed");
    runSeq(5, 16, 16'h7777, 2, 1'b1, "n5 flat score");
    runSeq(6, 0, 16'h3C5A, 4, 1'b0, "n6 zero iters");

    // R5 stray score while done
    keepScore = curScore;
    keepOrder = curOrder;
    strayReq++;
    repeat (4) @(negedge clk);
    check(curScore == keepScore, "R5", "stray score while done",
          64'(curScore), 64'(keepScore));
    check(curOrder == keepOrder, "R5", "order after stray score", curOrder, keepOrder);
    check(done === 1'b1, "R9", "done holds across stray score", 64'(done), 64'd1);

    summary();
    $finish;
  end

endmodule